// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character, written through a single-cycle data port, into an asynchronous serial frame on a line that idles high. Each frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The character can be 7 or 8 bits long. Parity can be absent, a constant zero, odd or even. The frame format is held in configuration registers, and those registers accept writes only while transmission is not enabled.

Timing comes from a single-cycle base tick, which an external baud generator supplies. Each bit lasts 16 base ticks. Two bits together form the enable: a power bit and a transmit-enable bit. The combined request is sampled on base ticks. The request can arm the transmitter only after the transmit circuit has been held disabled for at least two base ticks. After arming, one further base tick must pass before data writes are accepted. A busy flag covers each frame from the accepted write to the end of the last stop bit. A one-cycle completion pulse marks that end.

Top module: `uart_tx_core`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits with the least significant bit first, then the optional parity bit, then the high stop bit or bits.
- R2: Length select 0 sends 7 data bits, which are bits 6..0 of the written character. Length select 1 sends 8 data bits.
- R3: The 2-bit parity select works as follows. 00 sends no parity bit. 01 sends a parity bit that is always 0. 10 sends a parity bit that makes the number of ones across the sent data bits and the parity bit odd. 11 makes that number even.
- R4: Stop select 0 sends one stop bit and stop select 1 sends two stop bits.
- R5: The enable request is the power bit ANDed with the transmit-enable bit, sampled on base ticks. When either bit is 0, writes start no frame.
- R6: If the request is 0 at a base tick during a frame, the frame is abandoned. Busy falls one clock later, the line returns high, and no completion pulse is issued.
- R7: A rising request arms the transmitter only if the request was 0 for at least two base ticks before it. A request that rises earlier is ignored until the request has gone low again.
- R8: A data write is dropped unless at least one base tick has passed since the base tick at which the transmitter armed.
- R9: A configuration write is ignored while the transmit-enable bit is 1.
- R10: Each bit lasts 16 base ticks, counted from the first tick after the accepted write. Busy is high from the clock after the write until the last stop bit ends. At that point done pulses for exactly one clock.
- R11: A data write that arrives while busy is high is dropped, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Single-cycle base tick from the baud generator |
| power_en | input | 1 | Power bit of the transmitter |
| tx_en | input | 1 | Transmit-enable bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_parity | input | 2 | Parity select (00 none, 01 zero, 10 odd, 11 even) |
| cfg_len8 | input | 1 | Length select (0: 7 bits, 1: 8 bits) |
| cfg_stop2 | input | 1 | Stop select (0: one, 1: two) |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of the last stop bit |

## Verification
Frames are decoded at the middle of each bit, one pattern for each format. An 8-bit character with no parity and one stop bit checks bit order and timing. A 7-bit character with even parity shows that bit 7 of the character is left out of both the data and the parity sum. An 8-bit character with odd parity and two stop bits, and a 7-bit character with constant-zero parity, separate the four parity codes from each other and one stop bit from two. Other patterns target the sequencing rules: writes made too early after arming, a re-enable made too soon after disabling, a configuration write made while enabled, a write made while busy, power held off, and a frame cut off partway through.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    par_mode_e par;
    logic      len8;
    logic      stop2;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{par: PAR_NONE, len8: 1'b1, stop2: 1'b0};
endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       cfg_we,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_len8,
  input  logic       cfg_stop2,
  output tx_cfg_t    cfg_q
);
  tx_cfg_t cfg_d;
  logic    cfg_ce;

  assign cfg_ce = cfg_we & ~tx_en;

  always_comb begin
    cfg_d       = cfg_q;
    cfg_d.par   = par_mode_e'(cfg_parity);
    cfg_d.len8  = cfg_len8;
    cfg_d.stop2 = cfg_stop2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  // R9: format frozen while transmit enable is set
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> $stable(cfg_q));
endmodule

// File: rtl/uart_tx_enable.sv
module uart_tx_enable #(
  parameter int ARM_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic en_req,
  output logic active,
  output logic wr_ok
);
  localparam int CW = $clog2(ARM_TICKS + 1);
  localparam logic [CW-1:0] ARM_MAX = CW'(ARM_TICKS);

  logic          act_q, act_d;
  logic          ok_q, ok_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] low_q, low_d;

  always_comb begin
    act_d  = act_q;
    ok_d   = ok_q;
    prev_d = prev_q;
    low_d  = low_q;
    if (base_tick) begin
      prev_d = en_req;
      if (!en_req) begin
        act_d = 1'b0;
        ok_d  = 1'b0;
        if (low_q != ARM_MAX) low_d = low_q + 1'b1;
      end else begin
        low_d = '0;
        if (!act_q && !prev_q && (low_q == ARM_MAX)) act_d = 1'b1;
        if (act_q) ok_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ok_q   <= 1'b0;
      prev_q <= 1'b0;
      low_q  <= ARM_MAX;
    end else if (base_tick) begin
      act_q  <= act_d;
      ok_q   <= ok_d;
      prev_q <= prev_d;
      low_q  <= low_d;
    end
  end

  assign active = act_q;
  assign wr_ok  = ok_q;

  // R8: writes open only on a tick after arming
  p_wrok_after_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ok) |-> $past(active));
  // R5: no arming without a request
  p_arm_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(en_req));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              active,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  tx_cfg_t           cfg,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int BCW     = $clog2(FRAME_W + 1);
  localparam int TCW     = $clog2(OSR);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(OSR - 1);

  logic [FRAME_W-1:0] sh_q, sh_d, frame_c;
  logic [BCW-1:0]     bit_q, bit_d, nb_q, nb_d, nb_c;
  logic [TCW-1:0]     tick_q, tick_d;
  logic               busy_q, busy_d, done_q, done_d;
  logic               par_bit;
  logic [DATA_W-1:0]  masked;
  int                 nd;

  // frame assembly
  always_comb begin
    nd      = cfg.len8 ? DATA_W : DATA_W - 1;
    masked  = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nd) masked[i] = data[i];
    unique case (cfg.par)
      PAR_ODD:  par_bit = ~^masked;
      PAR_EVEN: par_bit = ^masked;
      default:  par_bit = 1'b0;
    endcase
    frame_c    = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nd) frame_c[1 + i] = data[i];
    if (cfg.par != PAR_NONE) frame_c[1 + nd] = par_bit;
    nb_c = BCW'(1 + nd + ((cfg.par != PAR_NONE) ? 1 : 0) + (cfg.stop2 ? 2 : 1));
  end

  // sequencing
  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    nb_d   = nb_q;
    tick_d = tick_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!active) begin
      busy_d = 1'b0;
      sh_d   = '1;
    end else if (load && !busy_q) begin
      sh_d   = frame_c;
      nb_d   = nb_c;
      bit_d  = '0;
      tick_d = '0;
      busy_d = 1'b1;
    end else if (busy_q && base_tick) begin
      if (tick_q == TICK_LAST) begin
        tick_d = '0;
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        if (bit_q == nb_q - 1'b1) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      bit_q  <= '0;
      nb_q   <= '0;
      tick_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      nb_q   <= nb_d;
      tick_q <= tick_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

  // R1: a frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R10: done is a single pulse at the end of a frame
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R11: the shift register holds its content between ticks while busy
  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !base_tick && active) |=> $stable(sh_q));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int ARM_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              power_en,
  input  logic              tx_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_len8,
  input  logic              cfg_stop2,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  tx_cfg_t cfg_q;
  logic    en_req, active, wr_ok, load;

  assign en_req = power_en & tx_en;
  assign load   = wr_valid & wr_ok;

  uart_tx_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .cfg_we     (cfg_we),
    .cfg_parity (cfg_parity),
    .cfg_len8   (cfg_len8),
    .cfg_stop2  (cfg_stop2),
    .cfg_q      (cfg_q)
  );

  uart_tx_enable #(.ARM_TICKS(ARM_TICKS)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .en_req    (en_req),
    .active    (active),
    .wr_ok     (wr_ok)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .active    (active),
    .load      (load),
    .data      (wr_data),
    .cfg       (cfg_q),
    .txd       (txd),
    .busy      (busy),
    .done      (done)
  );

  // R1: line idles high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R6: losing the armed state ends any frame
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!busy && !done));
endmodule

// File: tb/tb_uart_tx_core.sv
`timescale 1ns/1ps
module tb_uart_tx_core;
  logic       clk, rst_n, base_tick, power_en, tx_en, cfg_we;
  logic [1:0] cfg_parity;
  logic       cfg_len8, cfg_stop2, wr_valid;
  logic [7:0] wr_data;
  logic       txd, busy, done;
  int         n_checks, n_fail;
  bit         finished;

  uart_tx_core dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .power_en(power_en),
    .tx_en(tx_en), .cfg_we(cfg_we), .cfg_parity(cfg_parity),
    .cfg_len8(cfg_len8), .cfg_stop2(cfg_stop2), .wr_valid(wr_valid),
    .wr_data(wr_data), .txd(txd), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // base tick every 4 clocks, driven away from the active edge
  initial begin
    base_tick = 1'b0;
    forever begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        base_tick = (c == 3);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (!base_tick);
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] p, input logic l8, input logic s2);
    @(negedge clk);
    cfg_parity = p; cfg_len8 = l8; cfg_stop2 = s2; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic enable_on();
    @(negedge clk); power_en = 1'b1; tx_en = 1'b1;
    wait_ticks(2);
  endtask

  task automatic enable_off();
    @(negedge clk); tx_en = 1'b0;
    wait_ticks(3);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // expected frame computed from R1..R4
  task automatic build_exp(input logic [7:0] d, input logic [1:0] p, input logic l8,
                           input logic s2, output logic [11:0] eb, output int n);
    int nd, ones;
    nd = l8 ? 8 : 7;
    eb = '1; eb[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin
      eb[1 + i] = d[i];
      ones += d[i];
    end
    n = 1 + nd;
    if (p != 2'b00) begin
      if (p == 2'b01)      eb[n] = 1'b0;
      else if (p == 2'b10) eb[n] = (ones % 2 == 0);
      else                 eb[n] = (ones % 2 == 1);
      n++;
    end
    n += s2 ? 2 : 1;
  endtask

  // sends d and decodes the line at mid-bit
  task automatic send_check(input logic [7:0] d, input logic [1:0] p, input logic l8,
                            input logic s2, input string tag);
    logic [11:0] eb;
    int n, bad;
    logic [11:0] got;
    build_exp(d, p, l8, s2, eb, n);
    write_byte(d);
    bad = 0; got = '1;
    for (int k = 0; k < n; k++) begin
      wait_ticks(k == 0 ? 8 : 16);
      got[k] = txd;
      if (!busy) bad++;
    end
    check(got == eb, {tag, " frame bits"}, int'(got), int'(eb));
    check(bad == 0, "R10 busy during frame", bad, 0);
    wait_ticks(8);
    check(done && !busy, "R10 done at end of last stop", {busy, done}, 1);
    @(negedge clk);
    check(!done && txd, "R10 done single cycle", {done, txd}, 1);
  endtask

  task automatic t_reset();
    check(txd && !busy && !done, "R1 reset idle", {txd, busy, done}, 4);
  endtask

  task automatic t_power_off();
    @(negedge clk); power_en = 1'b0; tx_en = 1'b1;
    wait_ticks(3);
    write_byte(8'h3C);
    repeat (10) @(negedge clk);
    check(!busy && txd, "R5 power off blocks frames", {busy, txd}, 1);
    @(negedge clk); tx_en = 1'b0;
    wait_ticks(3);
  endtask

  task automatic t_early_write();
    @(negedge clk); power_en = 1'b1; tx_en = 1'b1;
    wait_ticks(1);
    write_byte(8'h55);
    repeat (3) @(negedge clk);
    check(!busy, "R8 write at arming tick dropped", busy, 0);
    wait_ticks(1);
    send_check(8'hA5, 2'b00, 1'b1, 1'b0, "R1 R8 8N1");
  endtask

  task automatic t_format(input logic [7:0] d, input logic [1:0] p, input logic l8,
                          input logic s2, input string tag);
    enable_off();
    set_cfg(p, l8, s2);
    enable_on();
    send_check(d, p, l8, s2, tag);
  endtask

  task automatic t_cfg_locked();
    set_cfg(2'b11, 1'b0, 1'b1);
    send_check(8'h96, 2'b00, 1'b1, 1'b0, "R9 cfg write while enabled");
  endtask

  task automatic t_fast_rearm();
    @(negedge clk); tx_en = 1'b0;
    wait_ticks(1);
    @(negedge clk); tx_en = 1'b1;
    wait_ticks(3);
    write_byte(8'h12);
    repeat (3) @(negedge clk);
    check(!busy, "R7 early re-enable ignored", busy, 0);
    enable_off();
    enable_on();
    send_check(8'h12, 2'b00, 1'b1, 1'b0, "R7 proper re-enable");
  endtask

  task automatic t_busy_write();
    int extra;
    write_byte(8'hF0);
    wait_ticks(40);
    write_byte(8'h0F);
    wait_ticks(130);
    extra = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (busy || !txd) extra++;
    end
    check(extra == 0, "R11 write while busy dropped", extra, 0);
  endtask

  task automatic t_abort();
    int dn;
    write_byte(8'h81);
    wait_ticks(40);
    @(negedge clk); tx_en = 1'b0;
    wait_ticks(1);
    @(negedge clk);
    check(!busy && txd, "R6 abort clears busy", {busy, txd}, 1);
    dn = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done || busy) dn++;
    end
    check(dn == 0, "R6 no done after abort", dn, 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; power_en = 1'b0; tx_en = 1'b0; cfg_we = 1'b0;
    cfg_parity = 2'b00; cfg_len8 = 1'b1; cfg_stop2 = 1'b0;
    wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_off();
    t_early_write();
    t_cfg_locked();
    t_format(8'hC5, 2'b11, 1'b0, 1'b0, "R2 R3 7E1");
    t_format(8'h31, 2'b10, 1'b1, 1'b1, "R3 R4 8O2");
    t_format(8'h7F, 2'b01, 1'b0, 1'b0, "R3 7 zero parity");
    t_format(8'h6A, 2'b11, 1'b1, 1'b1, "R3 R4 8E2");
    t_format(8'h5A, 2'b00, 1'b1, 1'b0, "R1 8N1 again");
    t_fast_rearm();
    t_busy_write();
    t_abort();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule